// File: doc/BRIEF.md
# Built-In Logic Block Observer Register

This block is a multi-bit register meant to sit between two blocks of combinational logic. Two control pins pick one of four behaviours, and the choice takes effect at the next rising clock edge. In its functional role the register captures its parallel input on every edge, like a plain pipeline stage. In its scan role the stages form one serial path from a scan input to a scan output, so several of these registers can be chained to load and unload test state. In its self-test role the register works as a multiple-input signature analyser. On every edge it folds the whole parallel input word into a linear feedback shift register, which compacts the responses of the logic that feeds it into one signature. A fourth code clears every stage.

The width and the feedback tap mask are parameters. The default tap mask encodes a primitive polynomial for the default width, so with all-zero data the register steps through every nonzero state. The register captures on every edge in every mode. It has no stall and no handshake, because the surrounding pipeline or test controller sets the timing.

Mode encoding, written as {ctl1, ctl0}: 2'b00 scan shift, 2'b01 signature, 2'b10 clear, 2'b11 parallel latch.

Top module: `bilbo_reg`

## Requirements
- R1: While rst_n is low, every stage of q_out is 0 and scan_out is 0.
- R2: With {ctl1,ctl0}=2'b11, q_out equals the value of d_in at the previous rising edge, and scan_in has no effect.
- R3: With {ctl1,ctl0}=2'b00, at each edge stage i takes the old stage i-1 and stage 0 takes scan_in, so q_out becomes {q_out[W-2:0], scan_in}. d_in has no effect.
- R4: scan_out always shows the top stage q_out[W-1], so after a shift edge it carries the old q_out[W-2].
- R5: With {ctl1,ctl0}=2'b01, stage i>0 takes the old stage i-1 XOR d_in[i]. Stage 0 takes d_in[0] XOR the feedback bit, which is the XOR of the old stages whose bit is set in TAP_MASK. scan_in has no effect.
- R6: With {ctl1,ctl0}=2'b10, every stage is 0 after the next edge, whatever the values of d_in and scan_in.
- R7: With a primitive tap mask, all-zero data and a nonzero start, the signature sequence never reaches zero and first returns to its start after exactly 2^W-1 edges.
- R8: A change on the control pins takes effect only at the rising edge. The edge applies the code present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl0 | input | 1 | Mode control, low bit |
| ctl1 | input | 1 | Mode control, high bit |
| d_in | input | WIDTH | Parallel data from the upstream logic |
| scan_in | input | 1 | Serial input of the scan path |
| q_out | output | WIDTH | Register contents |
| scan_out | output | 1 | Serial output; top stage |

## Verification
The in-RTL assertions check the one-edge effect of the latch, clear, shift and signature codes on every cycle, including the scan-out handoff. The bench sweeps every start state, data word and scan bit under all four codes on a 4-bit instance, and shows that d_in and scan_in are ignored where required. Only the bench scenarios show the reset state, the full maximal-length period of the signature sequence and the edge-only timing of mode changes.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT = 2'b00,
    MODE_SIGN  = 2'b01,
    MODE_CLEAR = 2'b10,
    MODE_LATCH = 2'b11
  } mode_e;
endpackage

// File: rtl/bilbo_mode_dec.sv
module bilbo_mode_dec
  import bilbo_pkg::*;
(
  input  logic  ctl0,
  input  logic  ctl1,
  output mode_e mode
);
  always_comb begin
    unique case ({ctl1, ctl0})
      2'b00:   mode = MODE_SHIFT;
      2'b01:   mode = MODE_SIGN;
      2'b10:   mode = MODE_CLEAR;
      default: mode = MODE_LATCH;
    endcase
  end
endmodule

// File: rtl/bilbo_feedback.sv
module bilbo_feedback #(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] TAP_MASK = 8'b1011_1000
) (
  input  logic [WIDTH-1:0] state,
  output logic             fb
);
  // Parity of the tapped stages.
  assign fb = ^(state & TAP_MASK);
endmodule

// File: rtl/bilbo_cell.sv
module bilbo_cell
  import bilbo_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode,
  input  logic  par_in,
  input  logic  chain_in,
  output logic  q
);
  logic nxt;

  always_comb begin
    unique case (mode)
      MODE_SHIFT: nxt = chain_in;
      MODE_SIGN:  nxt = chain_in ^ par_in;
      MODE_CLEAR: nxt = 1'b0;
      default:    nxt = par_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt;
  end
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
  import bilbo_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter logic [WIDTH-1:0] TAP_MASK = 8'b1011_1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl0,
  input  logic             ctl1,
  input  logic [WIDTH-1:0] d_in,
  input  logic             scan_in,
  output logic [WIDTH-1:0] q_out,
  output logic             scan_out
);
  localparam int unsigned TOP = WIDTH - 1;

  mode_e            mode;
  logic             fb;
  logic [WIDTH-1:0] chain;

  bilbo_mode_dec u_dec (
    .ctl0 (ctl0),
    .ctl1 (ctl1),
    .mode (mode)
  );

  bilbo_feedback #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_fb (
    .state (q_out),
    .fb    (fb)
  );

  // Stage 0 is fed from the scan pin when shifting, otherwise from feedback.
  assign chain[0] = (mode == MODE_SHIFT) ? scan_in : fb;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i > 0) begin : g_link
      assign chain[i] = q_out[i-1];
    end
    bilbo_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .par_in   (d_in[i]),
      .chain_in (chain[i]),
      .q        (q_out[i])
    );
  end

  assign scan_out = q_out[TOP];

  assert_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ({ctl1, ctl0} == 2'b11) |=> (q_out == $past(d_in)));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ({ctl1, ctl0} == 2'b10) |=> (q_out == '0));

  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ({ctl1, ctl0} == 2'b00) |=> (q_out == {$past(q_out[TOP-1:0]), $past(scan_in)}));

  assert_scan_handoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ({ctl1, ctl0} == 2'b00) |=> (scan_out == $past(q_out[TOP-1])));

  assert_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ({ctl1, ctl0} == 2'b01) |=>
      (q_out[TOP:1] == ($past(q_out[TOP-1:0]) ^ $past(d_in[TOP:1]))));
endmodule

// File: tb/bilbo_reg_tb.sv
module bilbo_reg_tb;
  localparam int W = 4;
  localparam logic [W-1:0] TAPS = 4'b1100;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ctl0 = 1'b0, ctl1 = 1'b0;
  logic [W-1:0] d_in = '0;
  logic         scan_in = 1'b0;
  logic [W-1:0] q_out;
  logic         scan_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bilbo_reg #(.WIDTH(W), .TAP_MASK(TAPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl0(ctl0), .ctl1(ctl1),
    .d_in(d_in), .scan_in(scan_in), .q_out(q_out), .scan_out(scan_out)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive inputs at the falling edge, clock once, sample at the next falling edge.
  task automatic step(input logic [1:0] code, input logic [W-1:0] d, input logic si);
    {ctl1, ctl0} = code;
    d_in = d;
    scan_in = si;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] model(input logic [1:0] code, input logic [W-1:0] s,
                                         input logic [W-1:0] d, input logic si);
    logic f;
    f = ^(s & TAPS);
    case (code)
      2'b00:   return {s[W-2:0], si};
      2'b01:   return {s[W-2:0], f} ^ d;
      2'b10:   return '0;
      default: return d;
    endcase
  endfunction

  initial begin
    @(negedge clk);
    check("R1 q", q_out, '0);
    check("R1 scan_out", {{(W-1){1'b0}}, scan_out}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // Exhaustive sweep: every code, start state, data word and scan bit.
    for (int code = 0; code < 4; code++) begin
      for (int s = 0; s < 16; s++) begin
        for (int d = 0; d < 16; d++) begin
          for (int si = 0; si < 2; si++) begin
            logic [W-1:0] exp;
            step(2'b11, W'(s), 1'b0);
            exp = model(2'(code), W'(s), W'(d), si[0]);
            step(2'(code), W'(d), si[0]);
            case (code)
              0: check("R3 shift", q_out, exp);
              1: check("R5 signature", q_out, exp);
              2: check("R6 clear", q_out, exp);
              default: check("R2 latch", q_out, exp);
            endcase
            check("R4 scan_out", {{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, exp[W-1]});
          end
        end
      end
    end

    // R7: maximal-length period from every nonzero start.
    for (int s = 1; s < 16; s++) begin
      int period;
      bit hit_zero;
      step(2'b11, W'(s), 1'b0);
      period = 0;
      hit_zero = 1'b0;
      for (int k = 1; k <= 15; k++) begin
        step(2'b01, '0, 1'b0);
        if (q_out == '0) hit_zero = 1'b1;
        if (period == 0 && q_out == W'(s)) period = k;
      end
      check("R7 period", W'(period), W'(15));
      check("R7 nonzero", {{(W-1){1'b0}}, hit_zero}, '0);
    end

    // R8: control change between edges leaves q_out untouched until the edge.
    step(2'b11, 4'hA, 1'b0);
    {ctl1, ctl0} = 2'b10;
    d_in = 4'h5;
    #5;
    check("R8 between edges", q_out, 4'hA);
    @(posedge clk);
    @(negedge clk);
    check("R8 at edge", q_out, 4'h0);

    // R1: asynchronous reset mid-run.
    step(2'b11, 4'hF, 1'b1);
    #3 rst_n = 1'b0;
    #2;
    check("R1 async", q_out, '0);
    check("R1 async scan_out", {{(W-1){1'b0}}, scan_out}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule